// File: doc/BRIEF.md
# Cascadable 32-bit Timer Pair

The block holds two 16-bit up-counters, a low-word timer and a high-word timer. Each has a control word, a count and a period. Each counts the core clock, the core clock gated by an input pin, or synchronized rising edges on that pin, through a prescaler. When a count equals its period, the next tick returns it to zero and raises that timer's interrupt flag. A pairing bit in the low timer's control word joins the two into one 32-bit counter. In that mode the low word's settings drive the whole counter, and the low word carries into the high word. The 32-bit period is {high period, low period}. The high timer's flag and its converter trigger then report the 32-bit match.

A register bus gives access to the counters. Its writes and reads complete in one cycle, and read data is combinational from the selected register. Register addresses are: 0 low control, 1 low count, 2 low period, 3 high control, 4 high count, 5 high period, 6 high-word hold (read only) and 7 flags. A read of the low count copies the high count into the hold register. This gives software a matching pair of words from two 16-bit reads.

Top module: `timer_pair`

## Requirements
- R1: After reset, both control words and both counts read 0 and both periods read 0xFFFF. Both flags and the trigger output are low.
- R2: Control bit 15 runs a timer. With the core clock selected, the prescaler at 1:1 and no gating, the count advances by one on every clock edge while the run bit is set. A write to a count address loads that count.
- R3: In 16-bit mode, a tick taken while the count equals the period sets the count to 0 and raises that timer's flag. Flags register bit 0 is the low flag and bit 1 is the high flag. Writing 1 to a bit clears that flag.
- R4: Control bits 5:4 select the prescale ratio: 00 gives 1:1, 01 gives 1:8, 10 gives 1:64 and 11 gives 1:256. The prescaler restarts on every write to that control word.
- R5: Control bit 6 selects gated mode while bit 1 is 0. The count then advances on the core clock only while the synchronized pin is high. A falling edge of the pin raises the flag.
- R6: Control bit 1 set selects the pin as the count source. The count advances once per synchronized rising edge of the pin.
- R7: In 16-bit mode, the trigger output pulses for one cycle after each period match of the high timer. The pulse comes together with the high flag.
- R8: Bit 3 of the low control word joins the pair. On a tick with the low count at 0xFFFF, the low count goes to 0 and the high count goes up by one.
- R9: In joined mode, a tick at {high count, low count} == {high period, low period} clears both words. It raises the high flag and pulses the trigger. The low flag stays low.
- R10: A read of the low count latches the high count into the hold register on the same edge. The held value stays until the next such read.
- R11: While the pair is joined, the high timer's own control word has no effect. The high count changes only through low-word ticks or a bus load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ext_pin | input | 1 | Gate or external clock pin |
| irq_lo | output | 1 | Low timer interrupt flag |
| irq_hi | output | 1 | High timer interrupt flag, or the 32-bit flag when joined |
| adc_trig | output | 1 | One-cycle converter trigger from the high timer's match |

## Verification
The case that matters is a bus read of the low count falling in the same cycle as a low-word carry into the high word. The bench loads the low count with 0xFFFF, starts the joined counter and reads the low count in the first running cycle, so the read and the carry share an edge. The read must return 0xFFFF and the hold register must return the pre-carry high word 0. The bench then reads the live high count to confirm that it went to 1 after that edge. This shows that the hold captured the word that matches the low-word sample, not the value after the carry.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL_LO = 3'd0,
        A_CNT_LO  = 3'd1,
        A_PER_LO  = 3'd2,
        A_CTRL_HI = 3'd3,
        A_CNT_HI  = 3'd4,
        A_PER_HI  = 3'd5,
        A_HOLD    = 3'd6,
        A_FLAGS   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic       en;
        logic [7:0] pad_a;
        logic       gate;
        logic [1:0] psel;
        logic       pair;
        logic       pad_b;
        logic       ext_clk;
        logic       pad_c;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w, input logic allow_pair);
        ctrl_t c;
        c       = ctrl_t'(w);
        c.pad_a = '0;
        c.pad_b = 1'b0;
        c.pad_c = 1'b0;
        if (!allow_pair) c.pair = 1'b0;
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
        logic [PRE_W-1:0] r;
        case (sel)
            2'b00:   r = PRE_W'(0);
            2'b01:   r = PRE_W'(7);
            2'b10:   r = PRE_W'(63);
            default: r = PRE_W'(255);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tp_pin_sync.sv
module tp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/tp_tick_gen.sv
module tp_tick_gen
    import timer_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic       gate,
    input  logic       ext_clk,
    input  logic [1:0] psel,
    input  logic       pin_level,
    input  logic       pin_rise,
    input  logic       pin_fall,
    output logic       tick,
    output logic       gate_fall
);
    logic [PRE_W-1:0] pcnt;
    logic             src;
    logic             at_last;

    always_comb begin
        if (ext_clk)   src = pin_rise;
        else if (gate) src = pin_level;
        else           src = 1'b1;
    end

    assign at_last   = (pcnt == presc_last(psel));
    assign tick      = run & src & at_last;
    assign gate_fall = run & gate & ~ext_clk & pin_fall;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pcnt <= '0;
        end else if (src) begin
            pcnt <= at_last ? '0 : pcnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/tp_count_word.sv
module tp_count_word #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/timer_pair.sv
module timer_pair
    import timer_pair_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_pin,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              adc_trig
);
    localparam int W = DATA_W;

    ctrl_t       ctrl_q [2];
    logic [W-1:0] per_q [2];
    logic [W-1:0] cnt_w [2];
    logic [W-1:0] hold_q;
    logic [1:0]  tick_w, gfall_w, ld_w, run_w, restart_w;
    logic [1:0]  clr_w, step_w, hit16;
    logic        pair_on, hit32, lo_full;
    logic        evt_lo, evt_hi, trig_evt;
    logic        pin_level, pin_rise, pin_fall;
    logic        flag_wr;

    assign pair_on = ctrl_q[0].pair;
    assign run_w   = {ctrl_q[1].en & ~pair_on, ctrl_q[0].en};
    assign flag_wr = bus_wr && (bus_addr == A_FLAGS);

    tp_pin_sync #(.STAGES(SYNC_STAGES)) i_pin (
        .clk(clk), .rst(rst), .pin(ext_pin),
        .level(pin_level), .rise(pin_rise), .fall(pin_fall)
    );

    for (genvar i = 0; i < 2; i++) begin : g_half
        localparam logic [ADDR_W-1:0] A_C = ADDR_W'(3 * i);
        localparam logic [ADDR_W-1:0] A_N = ADDR_W'(3 * i + 1);
        localparam logic [ADDR_W-1:0] A_P = ADDR_W'(3 * i + 2);

        assign restart_w[i] = bus_wr && (bus_addr == A_C);
        assign ld_w[i]      = bus_wr && (bus_addr == A_N);

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[i] <= '0;
                per_q[i]  <= '1;
            end else if (bus_wr) begin
                if (bus_addr == A_C) ctrl_q[i] <= ctrl_from_word(bus_wdata, i == 0);
                if (bus_addr == A_P) per_q[i]  <= bus_wdata;
            end
        end

        tp_tick_gen i_tick (
            .clk(clk), .rst(rst), .run(run_w[i]), .restart(restart_w[i]),
            .gate(ctrl_q[i].gate), .ext_clk(ctrl_q[i].ext_clk), .psel(ctrl_q[i].psel),
            .pin_level(pin_level), .pin_rise(pin_rise), .pin_fall(pin_fall),
            .tick(tick_w[i]), .gate_fall(gfall_w[i])
        );

        tp_count_word #(.W(W)) i_cnt (
            .clk(clk), .rst(rst), .load(ld_w[i]), .load_val(bus_wdata),
            .clear(clr_w[i]), .step(step_w[i]), .cnt(cnt_w[i])
        );

        assign hit16[i] = (cnt_w[i] == per_q[i]);
    end

    assign hit32   = ({cnt_w[1], cnt_w[0]} == {per_q[1], per_q[0]});
    assign lo_full = &cnt_w[0];

    always_comb begin
        if (pair_on) begin
            clr_w     = {2{tick_w[0] & hit32}};
            step_w[0] = tick_w[0] & ~hit32;
            step_w[1] = tick_w[0] & ~hit32 & lo_full;
            evt_lo    = 1'b0;
            evt_hi    = (tick_w[0] & hit32) | gfall_w[0];
            trig_evt  = tick_w[0] & hit32;
        end else begin
            clr_w     = tick_w & hit16;
            step_w    = tick_w & ~hit16;
            evt_lo    = clr_w[0] | gfall_w[0];
            evt_hi    = clr_w[1] | gfall_w[1];
            trig_evt  = clr_w[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_lo   <= 1'b0;
            irq_hi   <= 1'b0;
            adc_trig <= 1'b0;
            hold_q   <= '0;
        end else begin
            irq_lo   <= evt_lo | (irq_lo & ~(flag_wr & bus_wdata[0]));
            irq_hi   <= evt_hi | (irq_hi & ~(flag_wr & bus_wdata[1]));
            adc_trig <= trig_evt;
            if (bus_rd && bus_addr == A_CNT_LO) hold_q <= cnt_w[1];
        end
    end

    always_comb begin
        case (reg_addr_e'(bus_addr))
            A_CTRL_LO: bus_rdata = ctrl_q[0];
            A_CNT_LO:  bus_rdata = cnt_w[0];
            A_PER_LO:  bus_rdata = per_q[0];
            A_CTRL_HI: bus_rdata = ctrl_q[1];
            A_CNT_HI:  bus_rdata = cnt_w[1];
            A_PER_HI:  bus_rdata = per_q[1];
            A_HOLD:    bus_rdata = hold_q;
            default:   bus_rdata = {{(W-2){1'b0}}, irq_hi, irq_lo};
        endcase
    end
endmodule

// File: rtl/timer_pair_chk.sv
module timer_pair_chk
    import timer_pair_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pair_on,
    input logic              lo_tick,
    input logic [DATA_W-1:0] cnt_lo,
    input logic [DATA_W-1:0] cnt_hi,
    input logic [DATA_W-1:0] per_lo,
    input logic [DATA_W-1:0] per_hi,
    input logic              cnt_wr,
    input logic              rd_lo,
    input logic [DATA_W-1:0] hold,
    input logic              irq_lo,
    input logic              irq_hi,
    input logic              adc_trig
);
    logic m32;
    assign m32 = ({cnt_hi, cnt_lo} == {per_hi, per_lo});

    assert_trig_with_flag_R7: assert property (@(posedge clk) disable iff (rst)
        adc_trig |-> irq_hi);

    assert_lo_flag_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (pair_on && !irq_lo) |=> !irq_lo);

    assert_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (pair_on && lo_tick && (&cnt_lo) && !m32 && !cnt_wr)
        |=> (cnt_lo == '0) && (cnt_hi == DATA_W'($past(cnt_hi) + 1'b1)));

    assert_match_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (pair_on && lo_tick && m32 && !cnt_wr) |=> (cnt_lo == '0) && (cnt_hi == '0));

    assert_hold_latch_R10: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> (hold == $past(cnt_hi)));

    assert_odd_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (pair_on && !lo_tick && !cnt_wr) |=> $stable(cnt_hi));
endmodule

bind timer_pair timer_pair_chk i_chk (
    .clk(clk), .rst(rst), .pair_on(pair_on), .lo_tick(tick_w[0]),
    .cnt_lo(cnt_w[0]), .cnt_hi(cnt_w[1]), .per_lo(per_q[0]), .per_hi(per_q[1]),
    .cnt_wr(|ld_w), .rd_lo(bus_rd && bus_addr == 3'd1), .hold(hold_q),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .adc_trig(adc_trig)
);

// File: tb/test_timer_pair.sv
module test_timer_pair;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_pin = 1'b0;
    logic        irq_lo, irq_hi, adc_trig;

    int checks = 0;
    int errors = 0;
    int trig_seen = 0;
    bit done = 1'b0;

    localparam logic [2:0] CTRL_LO = 3'd0, CNT_LO = 3'd1, PER_LO = 3'd2,
                           CTRL_HI = 3'd3, CNT_HI = 3'd4, PER_HI = 3'd5,
                           HOLD = 3'd6, FLAGS = 3'd7;

    timer_pair i_timer_pair (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin(ext_pin), .irq_lo(irq_lo), .irq_hi(irq_hi), .adc_trig(adc_trig)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) if (adc_trig) trig_seen++;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(CTRL_LO, v); chk("R1", "low control", v, 0);
        rd(CTRL_HI, v); chk("R1", "high control", v, 0);
        rd(CNT_LO, v);  chk("R1", "low count", v, 0);
        rd(CNT_HI, v);  chk("R1", "high count", v, 0);
        rd(PER_LO, v);  chk("R1", "low period", v, 16'hFFFF);
        rd(PER_HI, v);  chk("R1", "high period", v, 16'hFFFF);
        chk("R1", "flags and trigger", {irq_hi, irq_lo, adc_trig}, 0);
    endtask

    task automatic t_count16;
        logic [15:0] v;
        wr(PER_LO, 16'd9);
        wr(CTRL_LO, 16'h8000);
        idle(13);
        wr(CTRL_LO, 16'h0000);
        rd(CNT_LO, v); chk("R3", "low count after 14 ticks, period 9", v, 4);
        chk("R3", "low flag after wrap", irq_lo, 1);
        wr(FLAGS, 16'h0001);
        chk("R3", "low flag after clear", irq_lo, 0);
        wr(CNT_LO, 16'h1234);
        rd(CNT_LO, v); chk("R2", "loaded low count", v, 16'h1234);
        wr(PER_LO, 16'hFFFF);
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        wr(CNT_LO, 16'h0);
        wr(CTRL_LO, 16'h8010); idle(39); wr(CTRL_LO, 16'h0);
        rd(CNT_LO, v); chk("R4", "1:8 over 40 clocks", v, 5);
        wr(CNT_LO, 16'h0);
        wr(CTRL_LO, 16'h8020); idle(199); wr(CTRL_LO, 16'h0);
        rd(CNT_LO, v); chk("R4", "1:64 over 200 clocks", v, 3);
        wr(CNT_LO, 16'h0);
        wr(CTRL_LO, 16'h8030); idle(599); wr(CTRL_LO, 16'h0);
        rd(CNT_LO, v); chk("R4", "1:256 over 600 clocks", v, 2);
    endtask

    task automatic t_hi16;
        logic [15:0] v;
        int base;
        wr(FLAGS, 16'h0003);
        wr(PER_HI, 16'd4);
        wr(CNT_HI, 16'd0);
        base = trig_seen;
        wr(CTRL_HI, 16'h8000); idle(11); wr(CTRL_HI, 16'h0);
        rd(CNT_HI, v); chk("R2", "high count after 12 ticks, period 4", v, 2);
        chk("R3", "high flag", irq_hi, 1);
        chk("R3", "low flag untouched", irq_lo, 0);
        chk("R7", "trigger pulses in 16-bit mode", trig_seen - base, 2);
        wr(PER_HI, 16'hFFFF);
    endtask

    task automatic t_join_carry;
        logic [15:0] v;
        wr(FLAGS, 16'h0003);
        wr(CNT_LO, 16'hFFFE); wr(CNT_HI, 16'h0000);
        wr(CTRL_LO, 16'h8008); idle(4); wr(CTRL_LO, 16'h0008);
        rd(CNT_LO, v); chk("R8", "low word after carry", v, 3);
        rd(HOLD, v);   chk("R10", "held high word", v, 1);
        rd(CNT_HI, v); chk("R8", "high word after carry", v, 1);
    endtask

    task automatic t_join_match;
        logic [15:0] v;
        int base;
        wr(FLAGS, 16'h0003);
        wr(PER_HI, 16'h0001); wr(PER_LO, 16'h0002);
        wr(CNT_LO, 16'hFFF0); wr(CNT_HI, 16'h0000);
        base = trig_seen;
        wr(CTRL_LO, 16'h8008); idle(19); wr(CTRL_LO, 16'h0008);
        rd(CNT_LO, v); chk("R9", "low word after 32-bit match", v, 1);
        rd(CNT_HI, v); chk("R9", "high word after 32-bit match", v, 0);
        chk("R9", "high flag on 32-bit match", irq_hi, 1);
        chk("R9", "low flag unused when joined", irq_lo, 0);
        chk("R9", "trigger on 32-bit match", trig_seen - base, 1);
        wr(PER_HI, 16'hFFFF); wr(PER_LO, 16'hFFFF);
    endtask

    task automatic t_hold_live;
        logic [15:0] lo, hi;
        wr(CNT_LO, 16'hFFFF); wr(CNT_HI, 16'h0000);
        wr(CTRL_LO, 16'h8008);
        rd(CNT_LO, lo);
        chk("R10", "low word read on carry edge", lo, 16'hFFFF);
        idle(10);
        rd(HOLD, hi); chk("R10", "hold keeps pre-carry high word", hi, 0);
        wr(CTRL_LO, 16'h0008);
        rd(CNT_HI, hi); chk("R8", "live high word moved on", hi, 1);
    endtask

    task automatic t_odd_ignored;
        logic [15:0] v;
        wr(FLAGS, 16'h0003);
        wr(CNT_HI, 16'h0000); wr(PER_HI, 16'h0001);
        wr(CTRL_HI, 16'h8000); idle(20);
        rd(CNT_HI, v); chk("R11", "high count idle while joined", v, 0);
        chk("R11", "high flag idle while joined", irq_hi, 0);
        wr(CTRL_HI, 16'h0000); wr(CTRL_LO, 16'h0000); wr(PER_HI, 16'hFFFF);
    endtask

    task automatic t_gate;
        logic [15:0] v;
        ext_pin = 1'b0;
        wr(CNT_LO, 16'h0); wr(FLAGS, 16'h0003);
        wr(CTRL_LO, 16'h8040); idle(5);
        rd(CNT_LO, v); chk("R5", "gated count with pin low", v, 0);
        ext_pin = 1'b1; idle(10);
        ext_pin = 1'b0; idle(6);
        chk("R5", "flag on gate falling edge", irq_lo, 1);
        wr(CTRL_LO, 16'h0);
        rd(CNT_LO, v); chk("R5", "clocks counted while pin high", v, 10);
    endtask

    task automatic t_ext;
        logic [15:0] v;
        wr(CNT_LO, 16'h0);
        wr(CTRL_LO, 16'h8002);
        for (int k = 0; k < 6; k++) begin
            ext_pin = 1'b1; idle(3);
            ext_pin = 1'b0; idle(3);
        end
        idle(4);
        wr(CTRL_LO, 16'h0);
        rd(CNT_LO, v); chk("R6", "pin rising edges counted", v, 6);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        t_reset();
        t_count16();
        t_prescale();
        t_hi16();
        t_join_carry();
        t_join_match();
        t_hold_live();
        t_odd_ignored();
        t_gate();
        t_ext();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule